// File: doc/BRIEF.md
# Host Slave Burst Interface

This block is the slave-side engine that lets an external host read and write an internal word-addressed memory. The host presents a start strobe with a word address and a direction. From then on the block generates every following address itself for as long as the host holds the burst line high. It drives a single-port memory interface, one access per beat, and it returns read data to the host.

Two timing protocols are available. The pipelined protocol runs one beat per cycle and returns each read word after a programmable pipe depth. The slow protocol puts a programmable number of internal wait cycles before every beat. Both protocols share a programmable idle gap after the end of a transaction.

A back-off input lets the host break a deadlock. It abandons the beat in progress, flags the abort so the host can retry, drops read data still in flight, and hands the bus to the host. The block keeps the grant until the host withdraws its bus request.

Top module: `hsb_slave`

## Requirements
- R1: After reset, ready_o is 1, and hbg_o, abort_o, rvalid_o and mem_req_o are all 0.
- R2: A start_i sampled while ready_o is 1 is accepted. In the pipelined protocol the first memory access (mem_req_o=1) takes place in the next cycle, at addr_i. It writes wdata_i from that cycle when wr_i was 1, and reads otherwise. No memory access takes place while ready_o is 1.
- R3: After each access during which burst_i is 1, a further beat follows at the next word address. The address wraps modulo 2^AW. The access during which burst_i is 0 is the last beat.
- R4: In the pipelined protocol (cfg_slow_i=0), beats occur on consecutive cycles. The data of each read is shown on rdata_o with rvalid_o=1 exactly D cycles after its access cycle, where D is cfg_pipe_i clamped to the range 1..MAX_PIPE.
- R5: In the slow protocol (cfg_slow_i=1), every beat is preceded by cfg_wait_i cycles without a memory access. Read data appears one cycle after the access.
- R6: After the last beat of a transaction, ready_o stays 0 for exactly cfg_idle_i cycles and then returns to 1.
- R7: A boff_i seen while a transaction is active suppresses the memory access of that cycle, so an aborted write beat never reaches memory. No further beats follow. abort_o is 1 for exactly one cycle, the cycle after.
- R8: From the cycle after the back-off, hbg_o is 1 and ready_o, rvalid_o and mem_req_o are 0. hbg_o stays 1 while hreq_i is 1 and drops in the cycle after hreq_i is seen at 0. Reads not delivered by the back-off cycle are discarded.
- R9: A boff_i while ready_o is 1 has no effect: hbg_o and abort_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_slow_i | input | 1 | 1 selects the slow protocol, 0 the pipelined one |
| cfg_pipe_i | input | PIPE_W | Read pipe depth for the pipelined protocol |
| cfg_wait_i | input | WAIT_W | Wait cycles before each slow beat |
| cfg_idle_i | input | IDLE_W | Idle cycles after a transaction |
| start_i | input | 1 | Start strobe carrying the first address |
| addr_i | input | AW | Starting word address |
| wr_i | input | 1 | 1 for a write transaction |
| burst_i | input | 1 | Held high to continue the burst |
| wdata_i | input | DW | Write data for the current beat |
| boff_i | input | 1 | Back-off request |
| hreq_i | input | 1 | Host bus request |
| ready_o | output | 1 | Able to accept a start |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DW | Read data |
| abort_o | output | 1 | Transaction abandoned by back-off |
| hbg_o | output | 1 | Bus granted to the host |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after a read |

## Verification
The checker assumes the configuration inputs stay constant while a transaction or its read pipe is active. It also assumes the host withdraws back-off after one cycle and holds hreq_i during the grant. The bench changes the protocol, pipe depth, wait and idle settings only while ready_o is 1 and the scoreboard is empty. It raises boff_i for a single cycle and uses an attached memory model with one-cycle read latency. Each read is predicted from a separate reference image, together with the cycle at which it must appear.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_GAP   = 2'd2,
    ST_GRANT = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_addr_ctr.sv
module hsb_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
    else if (step_i) addr_q <= addr_q + 1'b1;  // wraps mod 2^AW
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
  import hsb_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic              boff_i,
  input  logic              hreq_i,
  input  logic              cfg_slow_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [IDLE_W-1:0] cfg_idle_i,
  output logic              load_o,
  output logic              access_o,
  output logic              step_o,
  output logic              flush_o,
  output logic              ready_o,
  output logic              grant_o,
  output logic              abort_o
);
  localparam int CNT_W = (WAIT_W > IDLE_W) ? WAIT_W : IDLE_W;

  hsb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, wait_ld, idle_ld;
  logic             abort_q, in_beat;

  assign wait_ld  = cfg_slow_i ? CNT_W'(cfg_wait_i) : '0;
  assign idle_ld  = CNT_W'(cfg_idle_i);
  assign in_beat  = (state_q == ST_BEAT);
  assign access_o = in_beat && (cnt_q == '0) && !boff_i;
  assign flush_o  = in_beat && boff_i;
  assign step_o   = access_o && burst_i;
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign ready_o  = (state_q == ST_IDLE);
  assign grant_o  = (state_q == ST_GRANT);
  assign abort_o  = abort_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_BEAT;
        cnt_d   = wait_ld;
      end
      ST_BEAT: begin
        if (boff_i)              state_d = ST_GRANT;
        else if (cnt_q != '0)    cnt_d   = cnt_q - 1'b1;
        else if (burst_i)        cnt_d   = wait_ld;
        else if (idle_ld != '0) begin
          state_d = ST_GAP;
          cnt_d   = idle_ld;
        end else                 state_d = ST_IDLE;
      end
      ST_GAP: begin
        if (cnt_q <= 1)          state_d = ST_IDLE;
        else                     cnt_d   = cnt_q - 1'b1;
      end
      ST_GRANT: if (!hreq_i)     state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      abort_q <= flush_o;
    end
  end
endmodule

// File: rtl/hsb_rd_pipe.sv
module hsb_rd_pipe #(
  parameter int DW       = 32,
  parameter int MAX_PIPE = 4,
  parameter int PIPE_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              flush_i,
  input  logic [PIPE_W-1:0] depth_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o
);
  logic [MAX_PIPE-1:0] v_q;
  logic [DW-1:0]       d_q [MAX_PIPE-1];
  logic [DW-1:0]       tap [MAX_PIPE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else if (flush_i) v_q <= '0;
    else v_q <= {v_q[MAX_PIPE-2:0], issue_i};
  end

  // data stages follow the valid chain; no reset needed
  for (genvar j = 0; j < MAX_PIPE - 1; j++) begin : g_stage
    if (j == 0) begin : g_first
      always_ff @(posedge clk_i) d_q[0] <= mem_rdata_i;
    end else begin : g_next
      always_ff @(posedge clk_i) d_q[j] <= d_q[j-1];
    end
  end

  always_comb begin
    tap[0] = mem_rdata_i;
    for (int k = 1; k < MAX_PIPE; k++) tap[k] = d_q[k-1];
    rvalid_o = 1'b0;
    rdata_o  = '0;
    for (int k = 0; k < MAX_PIPE; k++) begin
      if (depth_i == PIPE_W'(k + 1)) begin
        rvalid_o = v_q[k];
        rdata_o  = tap[k];
      end
    end
  end
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave #(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int MAX_PIPE = 4,
  parameter int WAIT_W   = 4,
  parameter int IDLE_W   = 4,
  localparam int PIPE_W  = $clog2(MAX_PIPE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_slow_i,
  input  logic [PIPE_W-1:0] cfg_pipe_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [IDLE_W-1:0] cfg_idle_i,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              burst_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              boff_i,
  input  logic              hreq_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              abort_o,
  output logic              hbg_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic              load, access, step, flush, wr_q;
  logic [PIPE_W-1:0] depth_eff;

  hsb_seq #(.WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .burst_i, .boff_i, .hreq_i,
    .cfg_slow_i, .cfg_wait_i, .cfg_idle_i,
    .load_o(load), .access_o(access), .step_o(step), .flush_o(flush),
    .ready_o, .grant_o(hbg_o), .abort_o
  );

  hsb_addr_ctr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni, .load_i(load), .addr_i, .step_i(step), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_q <= 1'b0;
    else if (load) wr_q <= wr_i;
  end

  always_comb begin
    if (cfg_slow_i || cfg_pipe_i == '0)       depth_eff = PIPE_W'(1);
    else if (cfg_pipe_i > PIPE_W'(MAX_PIPE))  depth_eff = PIPE_W'(MAX_PIPE);
    else                                      depth_eff = cfg_pipe_i;
  end

  assign mem_req_o   = access;
  assign mem_we_o    = wr_q;
  assign mem_wdata_o = wdata_i;

  hsb_rd_pipe #(.DW(DW), .MAX_PIPE(MAX_PIPE), .PIPE_W(PIPE_W)) u_rd (
    .clk_i, .rst_ni, .issue_i(access && !wr_q), .flush_i(flush),
    .depth_i(depth_eff), .mem_rdata_i, .rvalid_o, .rdata_o
  );
endmodule

// File: rtl/hsb_slave_chk.sv
module hsb_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_slow_i,
  input logic          burst_i,
  input logic          boff_i,
  input logic          hreq_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          abort_o,
  input logic          hbg_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o
);
  assert_idle_no_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  assert_burst_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && burst_i && !cfg_slow_i) |=>
      (boff_i || (mem_req_o && mem_we_o == $past(mem_we_o) &&
                  mem_addr_o == $past(mem_addr_o) + 1'b1)));

  assert_boff_no_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boff_i && !ready_o) |-> !mem_req_o);

  assert_abort_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_abort_grants_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> hbg_o);

  assert_grant_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbg_o |-> (!rvalid_o && !mem_req_o && !ready_o));

  assert_grant_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hbg_o && hreq_i) |=> hbg_o);

  assert_grant_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hbg_o && !hreq_i) |=> !hbg_o);

  assert_idle_boff_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boff_i && ready_o) |=> (!hbg_o && !abort_o));
endmodule

bind hsb_slave hsb_slave_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_slow_i(cfg_slow_i), .burst_i(burst_i),
  .boff_i(boff_i), .hreq_i(hreq_i), .ready_o(ready_o), .rvalid_o(rvalid_o),
  .abort_o(abort_o), .hbg_o(hbg_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/hsb_slave_bench.sv
module hsb_slave_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_slow = 1'b0;
  logic [2:0]  cfg_pipe = 3'd1;
  logic [3:0]  cfg_wait = 4'd0, cfg_idle = 4'd0;
  logic        start = 1'b0, wr = 1'b0, burst = 1'b0, boff = 1'b0, hreq = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready_o, rvalid_o, abort_o, hbg_o, mem_req_o, mem_we_o;
  logic [31:0] rdata_o, mem_wdata_o, mem_rdata;
  logic [7:0]  mem_addr_o;

  int n_checks = 0, n_err = 0, cyc = 0, seed = 1;
  bit done = 0;
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  logic [31:0] exp_q [$];
  int          due_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsb_slave u_hsb_slave (
    .clk_i(clk), .rst_ni(rst_n), .cfg_slow_i(cfg_slow), .cfg_pipe_i(cfg_pipe),
    .cfg_wait_i(cfg_wait), .cfg_idle_i(cfg_idle), .start_i(start), .addr_i(addr),
    .wr_i(wr), .burst_i(burst), .wdata_i(wdata), .boff_i(boff), .hreq_i(hreq),
    .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .abort_o(abort_o),
    .hbg_o(hbg_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  // attached memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata <= mem[mem_addr_o];
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check_eq("R4/R8 unexpected read data (R8 discard)", 32'(rvalid_o), 32'd0);
      end else begin
        logic [31:0] d;
        int          c;
        d = exp_q.pop_front();
        c = due_q.pop_front();
        check_eq("R4/R5 read data", rdata_o, d);
        check_eq("R4/R5 read cycle", 32'(cyc), 32'(c));
      end
    end
  end

  task automatic burst_xfer(input bit w, input logic [7:0] a, input int n, input int abort_at);
    int weff, lat;
    weff = cfg_slow ? int'(cfg_wait) : 0;
    lat  = cfg_slow ? 1 : int'(cfg_pipe);
    while (!ready_o) @(negedge clk);
    start = 1'b1; addr = a; wr = w; burst = (n > 1);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] ak;
      ak = a + 8'(k);
      for (int i = 0; i < weff; i++) begin
        check_eq("R5 no access while waiting", 32'(mem_req_o), 32'd0);
        @(negedge clk);
      end
      if (k == abort_at) begin
        while (due_q.size() > 0 && due_q[$] > cyc) begin
          void'(due_q.pop_back());
          void'(exp_q.pop_back());
        end
        boff = 1'b1;
        wdata = 32'hDEAD_0000 | 32'(ak);
        @(negedge clk);
        boff = 1'b0; burst = 1'b0;
        check_eq("R7 abort flag", 32'(abort_o), 32'd1);
        check_eq("R8 grant after back-off", 32'(hbg_o), 32'd1);
        check_eq("R8 not ready while granted", 32'(ready_o), 32'd0);
        @(negedge clk);
        check_eq("R7 abort is one cycle", 32'(abort_o), 32'd0);
        return;
      end
      check_eq("R2 access in beat cycle", 32'(mem_req_o), 32'd1);
      check_eq("R3 beat address", 32'(mem_addr_o), 32'(ak));
      burst = (k < n - 1);
      if (w) begin
        seed  = seed * 1103 + 12345;
        wdata = 32'(seed);
        ref_mem[ak] = wdata;
      end else begin
        exp_q.push_back(ref_mem[ak]);
        due_q.push_back(cyc + lat);
      end
      @(negedge clk);
    end
    burst = 1'b0;
    for (int i = 0; i < int'(cfg_idle); i++) begin
      check_eq("R6 idle gap", 32'(ready_o), 32'd0);
      @(negedge clk);
    end
    check_eq("R6 ready after gap", 32'(ready_o), 32'd1);
  endtask

  task automatic release_grant(input int hold);
    for (int i = 0; i < hold; i++) begin
      check_eq("R8 grant held", 32'(hbg_o), 32'd1);
      check_eq("R8 no read data while granted", 32'(rvalid_o), 32'd0);
      @(negedge clk);
    end
    hreq = 1'b0;
    @(negedge clk);
    check_eq("R8 grant released", 32'(hbg_o), 32'd0);
    check_eq("R8 ready after release", 32'(ready_o), 32'd1);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check_eq("R4 scoreboard empty", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
      ref_mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check_eq("R1 ready", 32'(ready_o), 32'd1);
    check_eq("R1 grant", 32'(hbg_o), 32'd0);
    check_eq("R1 abort", 32'(abort_o), 32'd0);
    check_eq("R1 rvalid", 32'(rvalid_o), 32'd0);
    check_eq("R1 mem_req", 32'(mem_req_o), 32'd0);

    // R2 R3 R4: pipelined write then reads at several depths
    burst_xfer(1'b1, 8'h10, 8, -1);
    burst_xfer(1'b0, 8'h10, 8, -1);
    drain();
    cfg_pipe = 3'd3;
    burst_xfer(1'b0, 8'h12, 5, -1);
    drain();
    cfg_pipe = 3'd4;
    burst_xfer(1'b0, 8'h14, 2, -1);
    burst_xfer(1'b0, 8'h11, 1, -1);
    drain();

    // R3 wrap
    cfg_pipe = 3'd2;
    burst_xfer(1'b1, 8'hFE, 4, -1);
    burst_xfer(1'b0, 8'hFE, 4, -1);
    drain();

    // R5 slow protocol
    cfg_slow = 1'b1; cfg_wait = 4'd2;
    burst_xfer(1'b1, 8'h40, 1, -1);
    burst_xfer(1'b1, 8'h41, 3, -1);
    burst_xfer(1'b0, 8'h40, 4, -1);
    drain();

    // R6 idle gap
    cfg_slow = 1'b0; cfg_pipe = 3'd1; cfg_idle = 4'd3;
    burst_xfer(1'b0, 8'h41, 2, -1);
    drain();
    cfg_idle = 4'd0;

    // R9 back-off while idle
    boff = 1'b1;
    @(negedge clk);
    boff = 1'b0;
    check_eq("R9 no grant from idle back-off", 32'(hbg_o), 32'd0);
    check_eq("R9 no abort from idle back-off", 32'(abort_o), 32'd0);
    check_eq("R9 still ready", 32'(ready_o), 32'd1);

    // R7 R8 back-off in a write burst, then read back
    hreq = 1'b1;
    burst_xfer(1'b1, 8'h80, 4, 2);
    release_grant(3);
    burst_xfer(1'b0, 8'h80, 4, -1);
    drain();

    // R8 back-off with reads in flight
    cfg_pipe = 3'd3; hreq = 1'b1;
    burst_xfer(1'b0, 8'h20, 4, 2);
    release_grant(4);
    drain();

    // R7 back-off in slow mode, single-cycle grant
    cfg_slow = 1'b1; cfg_wait = 4'd1; hreq = 1'b1;
    burst_xfer(1'b1, 8'h90, 3, 1);
    release_grant(0);
    burst_xfer(1'b0, 8'h90, 3, -1);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule